// File: doc/BRIEF.md
# Quad DAC serial update controller

This block is the host-side master for a four-channel serial DAC that uses a three-wire write path plus a separate output-commit line. Each write is accepted on a valid/ready handshake. A write request carries a 2-bit channel select, a range bit, an 8-bit code, a defer flag and a commit flag. The block serialises the request onto the DAC pins. It then pulses the load strobe so the receiver latches the word. The serial clock, data, load strobe and commit line are all generated from the system clock through a programmable half-period divider.

A write without the defer flag updates its channel at once: the commit line is held low through the transfer, so the load pulse drives the output. A deferred write keeps the commit line high, so the receiver only stores the value. A later commit request produces one low pulse on the commit line, and every stored value reaches the outputs together. A frame-length option pads each transfer to 16 clocks with five leading zeros. This suits hosts that frame the word as two 8-clock bursts.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After reset the serial clock is low, load and commit lines are high, busy is low and ready is high.
- R2: A write shifts 11 bits, most significant first, in the order channel bit 1, channel bit 0, range, code bit 7 down to code bit 0. Channel code 0..3 selects outputs A..D. The receiver takes one bit on each falling serial-clock edge.
- R3: Serial data never changes on a falling serial-clock edge or while the serial clock stays high. It changes only at a rising edge or at request acceptance.
- R4: Every serial-clock phase lasts exactly div_i+1 system clocks, sampled at acceptance. This includes the low setup phase before the first rising edge.
- R5: Load stays high while the serial clock toggles. It falls exactly one half-period after the last falling edge, stays low exactly one half-period, then returns high.
- R6: A write with defer=0 drives the commit line low from acceptance until load returns high. The addressed output takes the new value at the load pulse. Values still pending from earlier deferred writes are committed by that falling edge.
- R7: A write with defer=1 keeps the commit line high throughout. Outputs are unchanged until a commit.
- R8: A request with commit=1 shifts nothing and produces exactly one commit-line low pulse one half-period wide. Every stored value then reaches its output. The pulse is produced even when nothing is pending.
- R9: With long_frame_i=1 at acceptance, a write uses 16 falling edges: five zero bits, then the 11 bits of R2.
- R10: Busy rises on acceptance and falls in the cycle load (or the commit line) returns high. Ready stays low until one further half-period has elapsed.
- R11: Between load or commit-line rising and the next commit-line falling edge there is at least one half-period.
- R12: The serial clock stays low whenever busy is low and whenever load is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIVW | Serial half-period minus one, in system clocks |
| long_frame_i | input | 1 | Pad the transfer to 16 serial clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_commit | input | 1 | Commit-only request (commit-line pulse) |
| req_defer | input | 1 | Store without updating the output |
| req_chan | input | 2 | Output channel select (0=A .. 3=D) |
| req_rng | input | 1 | Range bit sent with the code |
| req_code | input | 8 | DAC code |
| busy | output | 1 | Transfer or pulse in progress |
| dac_clk | output | 1 | Serial clock to the DAC |
| dac_data | output | 1 | Serial data to the DAC |
| dac_load | output | 1 | Load strobe, active low |
| dac_ldac | output | 1 | Output commit line, active low |

## Verification
The hardest case to reach from the ports is an immediate write issued while deferred values are still pending. When the commit line falls at the start of that write, the receiver applies every pending value as well as the addressed one. The stimulus table stages two deferred writes and commits them. It then stages a further deferred write followed by an immediate write to a different channel. A pin-level receiver model in the bench reports the resulting output state. A reset in the middle of a deferred transfer is also driven, to show that an unfinished frame leaves no output changed.

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_i,
  input  logic            long_frame_i,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_commit,
  input  logic            req_defer,
  input  logic [1:0]      req_chan,
  input  logic            req_rng,
  input  logic [7:0]      req_code,
  output logic            busy,
  output logic            dac_clk,
  output logic            dac_data,
  output logic            dac_load,
  output logic            dac_ldac
);
  localparam int FRAME = 16;
  localparam int SHORT = 11;
  localparam int PAD   = FRAME - SHORT;
  localparam int BW    = $clog2(FRAME + 1);

  typedef enum logic [2:0] {IDLE, SETUP, HI, LO, LDN, LPULSE, TAIL} st_t;

  st_t             st;
  logic [DIVW-1:0] cnt, div_q;
  logic [FRAME-1:0] sr;
  logic [BW-1:0]   left;
  logic            clk_q, load_q, ldac_q;

  wire             tick = (cnt == '0);
  wire [SHORT-1:0] word = {req_chan, req_rng, req_code};

  assign req_ready = (st == IDLE);
  assign busy      = !(st == IDLE || st == TAIL);
  assign dac_clk   = clk_q;
  assign dac_data  = sr[FRAME-1];
  assign dac_load  = load_q;
  assign dac_ldac  = ldac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      div_q  <= '0;
      sr     <= '0;
      left   <= '0;
      clk_q  <= 1'b0;
      load_q <= 1'b1;
      ldac_q <= 1'b1;
    end else if (st == IDLE) begin
      if (req_valid) begin
        div_q <= div_i;
        cnt   <= div_i;
        if (req_commit) begin
          st     <= LPULSE;
          ldac_q <= 1'b0;
        end else begin
          st     <= SETUP;
          ldac_q <= req_defer;
          sr     <= long_frame_i ? {{PAD{1'b0}}, word} : {word, {PAD{1'b0}}};
          left   <= long_frame_i ? BW'(FRAME) : BW'(SHORT);
        end
      end
    end else if (!tick) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= div_q;
      case (st)
        SETUP: begin st <= HI; clk_q <= 1'b1; end
        HI:    begin st <= LO; clk_q <= 1'b0; left <= left - 1'b1; end
        LO:
          if (left == '0) begin
            st     <= LDN;
            load_q <= 1'b0;
          end else begin
            st    <= HI;
            clk_q <= 1'b1;
            sr    <= {sr[FRAME-2:0], 1'b0};
          end
        LDN:    begin st <= TAIL; load_q <= 1'b1; ldac_q <= 1'b1; end
        LPULSE: begin st <= TAIL; ldac_q <= 1'b1; end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/quad_dac_ctrl_chk.sv
module quad_dac_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic dac_clk,
  input logic dac_data,
  input logic dac_load,
  input logic dac_ldac
);
  assert_data_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_clk) |-> $stable(dac_data));
  assert_data_while_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_clk && $past(dac_clk)) |-> $stable(dac_data));
  assert_load_high_shifting_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_clk |-> dac_load);
  assert_clk_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dac_clk);
  assert_ready_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  assert_busy_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));
  assert_ldac_fall_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ldac) |-> $past(req_valid && req_ready));
  assert_ldac_high_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_load) |-> dac_ldac);
endmodule

bind quad_dac_ctrl quad_dac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .dac_clk(dac_clk), .dac_data(dac_data),
  .dac_load(dac_load), .dac_ldac(dac_ldac)
);

// File: tb/sim_quad_dac_ctrl.sv
`timescale 1ns/1ps
module sim_quad_dac_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div_i = '0;
  logic long_frame_i = 1'b0, req_valid = 1'b0, req_commit = 1'b0, req_defer = 1'b0;
  logic [1:0] req_chan = '0;
  logic req_rng = 1'b0;
  logic [7:0] req_code = '0;
  logic req_ready, busy, dac_clk, dac_data, dac_load, dac_ldac;

  always #2.5 clk = ~clk;

  quad_dac_ctrl #(.DIVW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .long_frame_i(long_frame_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_commit(req_commit),
    .req_defer(req_defer), .req_chan(req_chan), .req_rng(req_rng),
    .req_code(req_code), .busy(busy), .dac_clk(dac_clk), .dac_data(dac_data),
    .dac_load(dac_load), .dac_ldac(dac_ldac)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin-level receiver model and timing monitor
  logic [8:0] inl [4], outm [4], exp_in [4], exp_out [4];
  logic [15:0] rsr = '0, last_frame = '0;
  int nf = 0, last_nf = 0, ldac_falls = 0, cyc = 0, cur_h = 1;
  int last_ev = 0, t_load_fall = 0, t_rise = -1000, t_ldac_fall = 0;
  bit bad_half = 0, bad_gap = 0, bad_lw = 0, bad_r11 = 0, bad_idle = 0, bad_busy = 0, bad_data = 0;
  logic p_clk = 0, p_load = 1, p_ldac = 1, p_busy = 0, p_data = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      nf = 0;
      t_rise = -1000;
    end else begin
      if (busy && !p_busy) last_ev = cyc;
      if (dac_clk != p_clk) begin
        if (cyc - last_ev != cur_h) bad_half = 1;
        last_ev = cyc;
        if (!busy || !dac_load) bad_idle = 1;
        if (!dac_clk) begin
          if (dac_data != p_data) bad_data = 1;
          rsr = {rsr[14:0], dac_data};
          nf++;
        end
      end
      if (dac_ldac == 1'b0 && p_ldac) begin
        if (cyc - t_rise < cur_h) bad_r11 = 1;
        t_ldac_fall = cyc;
        ldac_falls++;
        for (int i = 0; i < 4; i++) outm[i] = inl[i];
      end
      if (!dac_load && p_load) begin
        if (cyc - last_ev != cur_h) bad_gap = 1;
        t_load_fall = cyc;
        last_frame = rsr;
        last_nf = nf;
        nf = 0;
        inl[rsr[10:9]] = rsr[8:0];
        if (!dac_ldac) outm[rsr[10:9]] = rsr[8:0];
      end
      if (dac_load && !p_load) begin
        if (cyc - t_load_fall != cur_h) bad_gap = 1;
        t_rise = cyc;
      end
      if (dac_ldac && !p_ldac && p_load) begin
        if (cyc - t_ldac_fall != cur_h) bad_lw = 1;
        t_rise = cyc;
      end
      if (!busy && p_busy)
        if (!((dac_load && !p_load) || (dac_ldac && !p_ldac)) || req_ready) bad_busy = 1;
    end
    p_clk = dac_clk; p_load = dac_load; p_ldac = dac_ldac; p_busy = busy; p_data = dac_data;
  end

  // {commit, defer, long, chan[1:0], rng, code[7:0], div[7:0]}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'hA5, 8'd0},
    {1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 8'h3C, 8'd2},
    {1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 8'h81, 8'd1},
    {1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 8'h7E, 8'd0},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd1},
    {1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 8'hFF, 8'd3},
    {1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 8'h00, 8'd0},
    {1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 8'h01, 8'd0},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd2},
    {1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 8'h55, 8'd0},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd0}
  };

  task automatic send(input logic [21:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    {req_commit, req_defer, long_frame_i, req_chan, req_rng, req_code, div_i} = v;
    cur_h = int'(v[7:0]) + 1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      inl[i] = '0; outm[i] = '0; exp_in[i] = '0; exp_out[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!dac_clk && dac_load && dac_ldac && !busy && req_ready, "R1 reset levels",
        {dac_clk, dac_load, dac_ldac, busy, req_ready}, 5'b01101);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      int f0;
      v = VEC[k];
      f0 = ldac_falls;
      send(v);
      chk(busy && !req_ready, "R10 busy after accept", {busy, req_ready}, 2'b10);
      if (v[21]) begin
        for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
      end else begin
        if (!v[20]) for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
        exp_in[v[18:17]] = v[16:8];
        if (!v[20]) exp_out[v[18:17]] = v[16:8];
      end
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        chk(outm[i] == exp_out[i], v[21] ? "R8 commit outputs" : (v[20] ? "R7 deferred outputs" : "R6 immediate outputs"),
            outm[i], exp_out[i]);
      if (v[21]) chk(ldac_falls - f0 == 1, "R8 one commit pulse", ldac_falls - f0, 1);
      else if (v[20]) chk(ldac_falls - f0 == 0, "R7 commit line held high", ldac_falls - f0, 0);
      else chk(ldac_falls - f0 == 1, "R6 commit line low for write", ldac_falls - f0, 1);
      if (!v[21]) begin
        chk(last_nf == (v[19] ? 16 : 11), v[19] ? "R9 edge count" : "R2 edge count", last_nf, v[19] ? 16 : 11);
        chk(last_frame[10:0] == v[18:8], "R2 frame bits", last_frame[10:0], v[18:8]);
        if (v[19]) chk(last_frame[15:11] == 5'd0, "R9 zero padding", last_frame[15:11], 0);
      end
    end

    // reset in the middle of a deferred transfer leaves outputs unchanged
    send({1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 8'hC3, 8'd1});
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!dac_clk && dac_load && dac_ldac && !busy && req_ready, "R1 levels after reset",
        {dac_clk, dac_load, dac_ldac, busy, req_ready}, 5'b01101);
    rst_n = 1'b1;
    send({1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd0});
    for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(outm[1] == exp_out[1], "R7 aborted frame ignored", outm[1], exp_out[1]);

    chk(!bad_data, "R3 data stable at fall", bad_data, 0);
    chk(!bad_half, "R4 half-period", bad_half, 0);
    chk(!bad_gap, "R5 load timing", bad_gap, 0);
    chk(!bad_lw, "R8 commit pulse width", bad_lw, 0);
    chk(!bad_busy, "R10 busy release", bad_busy, 0);
    chk(!bad_r11, "R11 rise to commit gap", bad_r11, 0);
    chk(!bad_idle, "R12 clock idle", bad_idle, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule